// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block sits on the host side of a four-wire serial programming link and brings a target microcontroller into its programming mode. On a start request it holds the clock line low, gives the target's reset line a high pulse, lowers reset and waits a settling time. It then shifts out a four-byte enable instruction and listens to the byte returned while the third byte goes out.

When the target has locked onto the bit stream, it echoes the second instruction byte (0x53) during the third byte. The sequencer then reports the link as synchronized and keeps reset low, so that later programming traffic can follow. When the echo is wrong, the sequencer still finishes all four bytes. It then pulses reset again, waits again and repeats the instruction. After a set number of failed attempts it raises a failure flag and returns to idle.

The clock half-period, the reset pulse width and the settling wait are counted in system clocks and set by parameters. The default settling wait is 20 ms at 125 MHz. A simulation can pass much shorter values.

Top module: `prog_entry_seq`

## Requirements
- R1: After system reset, `tgt_reset_o` is high, `sck_o` and `mosi_o` are low, and `busy_o`, `synced_o` and `failed_o` are low.
- R2: On `start_i`, `tgt_reset_o` is held high for at least `RST_PULSE` clocks while `sck_o` stays low. It then goes low. Whenever `tgt_reset_o` is high, `sck_o` is low.
- R3: After `tgt_reset_o` falls, at least `SETTLE_WAIT` clocks pass before the first rising edge of `sck_o`.
- R4: The instruction bytes are, in order, `EN_B0` (default 0xAC), 0x53, `EN_B2` (default 0x00) and `EN_B3` (default 0x00), each sent MSB first. `mosi_o` changes only while `sck_o` is low, and it is stable across every rising edge.
- R5: Every attempt produces exactly 32 rising edges of `sck_o`, whether the echo matched or not.
- R6: The host samples `miso_i` at each rising edge of `sck_o`. If the eight bits gathered during the third byte equal 0x53, then after the fourth byte `synced_o` goes high and stays high, and `tgt_reset_o` stays low.
- R7: On a mismatch, the sequencer pulses `tgt_reset_o` high for exactly `RST_PULSE` clocks with `sck_o` low. It then waits the settling time and resends all four bytes.
- R8: When `MAX_TRIES` attempts have all mismatched, `failed_o` goes high and `synced_o` stays low. The block returns to idle with `tgt_reset_o` high and no further `sck_o` activity. `failed_o` stays high until the next start.
- R9: `busy_o` is high while a byte is being shifted, and `sck_o` is high only while `busy_o` is high.
- R10: Each high phase of `sck_o` lasts exactly `SCK_HALF` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin an entry sequence |
| miso_i | input | 1 | Serial data from the target |
| tgt_reset_o | output | 1 | Target reset line level (high = target held in normal reset pulse / released) |
| sck_o | output | 1 | Serial clock to the target |
| mosi_o | output | 1 | Serial data to the target |
| busy_o | output | 1 | High while a byte is being shifted |
| synced_o | output | 1 | Link is synchronized; target is held in programming mode |
| failed_o | output | 1 | All attempts failed to synchronize |

## Verification
The bench uses a behavioural target that echoes each received byte during the next byte. For a chosen number of attempts it corrupts that echo with a random mask, which can be a single bit flip.

The corner cases it targets are these:
- A match on the very first attempt.
- A match on the last allowed attempt. A design with an off-by-one retry limit would report failure here.
- Exhaustion of every attempt. A design with a wrong limit would keep retrying or synchronize when it should not.
- A mismatch, after which the bench checks that all 32 bits still go out. A design that aborted early would drop bits.
- Every retry, for which the bench checks that the reset pulse width and the settling gap are measured exactly. A design that skipped the wait would start clocking too early.

// File: rtl/prog_entry_pkg.sv
// Package: shared state encoding and fixed constants of the entry sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package prog_entry_pkg;

    // Byte the target returns during the third instruction byte when in step.
    localparam logic [7:0] SYNC_ECHO = 8'h53;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_SETTLE,
        ST_LOAD,
        ST_WAIT,
        ST_SYNCED
    } seq_state_t;

endpackage

// File: rtl/wait_timer.sv
// Module: wait_timer
// Loadable down-counter. A load of length N raises expired_o on the Nth
// clock after the load edge, for one clock.
// Assumes: len_i >= 1; no reload while running except by a fresh load.
module wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);

    logic [W-1:0] cnt;
    logic         running;

    // Count down from the loaded length and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load_i) begin
            cnt     <= len_i - W'(1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - W'(1);
        end
    end

    // Expiry is the last counted cycle.
    always_comb expired_o = running && (cnt == '0);

endmodule

// File: rtl/sck_byte_shifter.sv
// Module: sck_byte_shifter
// Shifts one byte out MSB first with the clock idle low. Data changes on the
// falling edge and is set up a half period before each rising edge. Incoming
// bits are captured at the rising edge.
// Assumes: load_i only while busy_o is low; HALF >= 1.
module sck_byte_shifter #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] data_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rx_o
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic [7:0]    sr;
    logic [2:0]    bit_n;
    logic          phase_hi;

    // Half-period timing, bit shifting and capture of the returned bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sr       <= '0;
            bit_n    <= '0;
            phase_hi <= 1'b0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            rx_o     <= '0;
        end else begin
            done_o <= 1'b0;
            if (load_i) begin
                sr       <= data_i;
                bit_n    <= '0;
                phase_hi <= 1'b0;
                cnt      <= '0;
                busy_o   <= 1'b1;
            end else if (busy_o) begin
                if (cnt == CNT_END) begin
                    cnt <= '0;
                    if (!phase_hi) begin
                        phase_hi <= 1'b1;
                        rx_o     <= {rx_o[6:0], miso_i};
                    end else begin
                        phase_hi <= 1'b0;
                        sr       <= {sr[6:0], 1'b0};
                        if (bit_n == 3'd7) begin
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                        end else begin
                            bit_n <= bit_n + 3'd1;
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // Pin views of the shift state.
    always_comb begin
        sck_o  = phase_hi;
        mosi_o = sr[7];
    end

endmodule

// File: rtl/prog_entry_seq.sv
// Module: prog_entry_seq (top)
// Drives the reset pulse and the settling wait, then sends the four-byte
// enable instruction. It checks the echo during the third byte and retries
// up to MAX_TRIES times.
// Assumes: start_i is a single-cycle pulse; all timing parameters >= 1.
module prog_entry_seq
    import prog_entry_pkg::*;
#(
    parameter int         SCK_HALF    = 4,
    parameter int         RST_PULSE   = 16,
    parameter int         SETTLE_WAIT = 2500000,
    parameter int         MAX_TRIES   = 8,
    parameter logic [7:0] EN_B0       = 8'hAC,
    parameter logic [7:0] EN_B2       = 8'h00,
    parameter logic [7:0] EN_B3       = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic miso_i,
    output logic tgt_reset_o,
    output logic sck_o,
    output logic mosi_o,
    output logic busy_o,
    output logic synced_o,
    output logic failed_o
);

    localparam int TMAX = (RST_PULSE > SETTLE_WAIT) ? RST_PULSE : SETTLE_WAIT;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int NW   = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [NW-1:0] LAST_TRY = NW'(MAX_TRIES - 1);

    seq_state_t    state;
    logic [1:0]    byte_idx;
    logic [NW-1:0] tries;
    logic          echo_ok;
    logic          failed;
    logic          tmr_load;
    logic [TW-1:0] tmr_len;
    logic          tmr_expired;
    logic [7:0]    tx_byte;
    logic          sh_done;
    logic [7:0]    sh_rx;
    logic          retry_now;

    // A retry is due after the fourth byte when the echo was wrong and
    // attempts remain.
    always_comb retry_now = (state == ST_WAIT) && sh_done && (byte_idx == 2'd3)
                            && !echo_ok && (tries != LAST_TRY);

    // Select the timer length for the pulse or the settling wait.
    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = TW'(RST_PULSE);
        if (((state == ST_IDLE) || (state == ST_SYNCED)) && start_i) begin
            tmr_load = 1'b1;
        end else if (retry_now) begin
            tmr_load = 1'b1;
        end else if ((state == ST_PULSE) && tmr_expired) begin
            tmr_load = 1'b1;
            tmr_len  = TW'(SETTLE_WAIT);
        end
    end

    // Pick the instruction byte for the current position.
    always_comb begin
        case (byte_idx)
            2'd0:    tx_byte = EN_B0;
            2'd1:    tx_byte = SYNC_ECHO;
            2'd2:    tx_byte = EN_B2;
            default: tx_byte = EN_B3;
        endcase
    end

    // Main sequence: pulse, settle, shift four bytes, judge the echo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_idx <= '0;
            tries    <= '0;
            echo_ok  <= 1'b0;
            failed   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_SYNCED: begin
                    if (start_i) begin
                        failed <= 1'b0;
                        tries  <= '0;
                        state  <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (tmr_expired) state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tmr_expired) begin
                        byte_idx <= '0;
                        echo_ok  <= 1'b0;
                        state    <= ST_LOAD;
                    end
                end
                ST_LOAD: state <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_done) begin
                        if (byte_idx == 2'd2) echo_ok <= (sh_rx == SYNC_ECHO);
                        if (byte_idx == 2'd3) begin
                            if (echo_ok) begin
                                state <= ST_SYNCED;
                            end else if (retry_now) begin
                                tries <= tries + NW'(1);
                                state <= ST_PULSE;
                            end else begin
                                failed <= 1'b1;
                                state  <= ST_IDLE;
                            end
                        end else begin
                            byte_idx <= byte_idx + 2'd1;
                            state    <= ST_LOAD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    wait_timer #(.W(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_expired)
    );

    sck_byte_shifter #(.HALF(SCK_HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state == ST_LOAD),
        .data_i (tx_byte),
        .miso_i (miso_i),
        .sck_o  (sck_o),
        .mosi_o (mosi_o),
        .busy_o (busy_o),
        .done_o (sh_done),
        .rx_o   (sh_rx)
    );

    // Status and reset-line outputs decoded from the state.
    always_comb begin
        tgt_reset_o = (state == ST_IDLE) || (state == ST_PULSE);
        synced_o    = (state == ST_SYNCED);
        failed_o    = failed;
    end

endmodule

// File: rtl/prog_entry_seq_chk.sv
// Module: prog_entry_seq_chk
// Port-level protocol checks for prog_entry_seq, attached by bind.
// Assumes: the same clock and reset as the checked instance.
module prog_entry_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tgt_reset_o,
    input logic sck_o,
    input logic mosi_o,
    input logic busy_o,
    input logic synced_o,
    input logic failed_o
);

    // R2: the clock stays low while reset is high.
    assert_sck_low_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset_o |-> (!sck_o && !busy_o));

    // R4: data holds steady through every clock high phase.
    assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R6: once synchronized, the target is kept in programming reset.
    assert_synced_reset_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        synced_o |-> (!tgt_reset_o && !failed_o));

    // R8: a failure leaves the block idle with reset released.
    assert_failed_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        failed_o |-> (tgt_reset_o && !busy_o && !synced_o));

    // R9: the clock is only high while a byte is in flight.
    assert_sck_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> busy_o);

endmodule

bind prog_entry_seq prog_entry_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_reset_o (tgt_reset_o),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .busy_o      (busy_o),
    .synced_o    (synced_o),
    .failed_o    (failed_o)
);

// File: tb/tb_prog_entry_seq.sv
// Bench for prog_entry_seq: a behavioural target echoes each byte during the
// next one, corrupting it for a chosen number of attempts.
module tb_prog_entry_seq;

    localparam int HALF   = 2;
    localparam int PULSE  = 5;
    localparam int SETTLE = 40;
    localparam int TRIES  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic tgt_reset, sck, mosi, busy, synced, failed;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    prog_entry_seq #(
        .SCK_HALF(HALF), .RST_PULSE(PULSE), .SETTLE_WAIT(SETTLE), .MAX_TRIES(TRIES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .miso_i(miso),
        .tgt_reset_o(tgt_reset), .sck_o(sck), .mosi_o(mosi),
        .busy_o(busy), .synced_o(synced), .failed_o(failed)
    );

    // Expected instruction byte at a given position.
    function automatic logic [7:0] exp_byte(input int i);
        case (i)
            0:       return 8'hAC;
            1:       return 8'h53;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural target: samples on rising SCK, launches on falling SCK.
    int         bad_n   = 0;
    int         t_att   = 0;
    int         t_bits  = 0;
    logic [7:0] t_in    = '0;
    logic [7:0] t_out   = '0;
    logic [7:0] bad_msk = 8'h01;

    always @(negedge tgt_reset) t_att++;

    always @(posedge sck or posedge tgt_reset) begin
        if (tgt_reset) begin
            t_bits = 0;
            t_out  = '0;
        end else begin
            t_in = {t_in[6:0], mosi};
            t_bits++;
            if (t_bits % 8 == 0)
                t_out = (t_att > bad_n) ? t_in : (t_in ^ bad_msk);
        end
    end

    always @(negedge sck) begin
        miso  = t_out[7];
        t_out = {t_out[6:0], 1'b0};
    end

    // Port monitor sampled between clock edges.
    logic       p_sck = 1'b0, p_rst = 1'b1;
    int         hi_cnt = 0, lo_cnt = 0, sck_hi = 0;
    int         attempts = 0, bits = 0;
    bit         first_wait = 1'b0;
    logic [7:0] acc = '0;

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (tgt_reset) hi_cnt++;
            if (p_rst && !tgt_reset) begin
                if (attempts == 0)
                    check(hi_cnt >= PULSE, "R2", hi_cnt, PULSE);
                else begin
                    check(hi_cnt == PULSE, "R7", hi_cnt, PULSE);
                    check(bits == 32, "R5", bits, 32);
                end
                attempts++;
                bits = 0;
                lo_cnt = 0;
                first_wait = 1'b1;
            end
            if (!p_rst && tgt_reset) hi_cnt = 1;
            if (!tgt_reset && first_wait) lo_cnt++;
            if (sck) sck_hi++;
            if (p_sck && !sck) begin
                check(sck_hi == HALF, "R10", sck_hi, HALF);
                sck_hi = 0;
            end
            if (!p_sck && sck) begin
                if (first_wait) begin
                    check(lo_cnt >= SETTLE, "R3", lo_cnt, SETTLE);
                    first_wait = 1'b0;
                end
                check(busy == 1'b1, "R9", busy, 1);
                acc = {acc[6:0], mosi};
                bits++;
                if (bits % 8 == 0)
                    check(acc == exp_byte(bits / 8 - 1), "R4", acc, exp_byte(bits / 8 - 1));
            end
        end
        p_sck = sck;
        p_rst = tgt_reset;
    end

    // One entry sequence with a given number of corrupted attempts.
    task automatic run_trial(input int nbad, input logic [7:0] msk);
        int guard;
        bad_n    = nbad;
        bad_msk  = msk;
        t_att    = 0;
        attempts = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!synced && !failed && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check(bits == 32, "R5", bits, 32);
        if (nbad < TRIES) begin
            check(synced == 1'b1, "R6", synced, 1);
            check(tgt_reset == 1'b0, "R6", tgt_reset, 0);
            check(attempts == nbad + 1, "R7", attempts, nbad + 1);
            check(failed == 1'b0, "R8", failed, 0);
        end else begin
            check(failed == 1'b1, "R8", failed, 1);
            check(synced == 1'b0, "R8", synced, 0);
            check(attempts == TRIES, "R8", attempts, TRIES);
            repeat (20) @(negedge clk);
            check(tgt_reset == 1'b1 && sck == 1'b0 && busy == 1'b0, "R8",
                  {tgt_reset, sck, busy}, 3'b100);
            check(failed == 1'b1, "R8", failed, 1);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(negedge clk) begin
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(tgt_reset == 1'b1, "R1", tgt_reset, 1);
        check({sck, mosi, busy, synced, failed} == 5'b0, "R1",
              {sck, mosi, busy, synced, failed}, 0);
        // Directed corners: first attempt, last attempt, full exhaustion.
        run_trial(0, 8'h01);
        run_trial(TRIES - 1, 8'h80);
        run_trial(TRIES, 8'hFF);
        run_trial(1, 8'h10);
        // Random mix of echo corruption patterns.
        for (int k = 0; k < 20; k++)
            run_trial($urandom_range(0, TRIES), 8'($urandom_range(1, 255)));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule